// File: doc/BRIEF.md
# Serial Character Receiver with Tagged Holding Stage

This block receives asynchronous serial characters on one line. A clock enable runs at sixteen times the bit rate. A falling edge on the synchronized line starts a counter. The start bit is confirmed at its centre. Each later bit (data, then optional parity, then stop) is sampled once at its centre. The bits collect in a shift register. When the stop bit has been sampled, the character moves into a single holding stage together with three error tags.

Software reads the held byte with a one-cycle read strobe. A line-status output shows data-ready, overrun and the three tags. The tags always describe the byte that is currently held, and they drop to zero once that byte is read. A separate strobe clears the overrun flag. An interrupt output, gated by an enable input, is high while a character is waiting.

Top module: `uart_tagged_rx`

## Requirements
- R1: After reset, line_status is 0, irq is 0 and no character is held.
- R2: The line is checked 8 oversampling ticks after a detected falling edge. If it is low there, the character proceeds. If it is high, the attempt is discarded, no character is produced and line_status bit 0 stays 0.
- R3: cfg_wlen selects the word length, 0..3 meaning 5..8 bits. Data arrives least significant bit first. The result is right-justified in rx_byte and the unused upper bits are 0.
- R4: When cfg_par_en is 1, one parity bit follows the data. cfg_par_odd=1 selects odd parity and 0 selects even. A mismatch sets line_status bit 2 for that character.
- R5: A stop bit sampled low sets line_status bit 3 (framing error) for that character.
- R6: If the start bit, the data bits, the parity bit and the stop bit are all sampled low, the character is held with rx_byte 0 and line_status bits 4 and 3 set. After such a break, no new character starts until the line has been seen high.
- R7: line_status bit 0 is 1 exactly while a character is held. Bits 4:2 are 0 whenever bit 0 is 0.
- R8: A one-cycle rd_data pulse empties the holding stage, clearing line_status bits 0 and 4:2 on the next cycle.
- R9: If a character completes while one is still held, it replaces the held byte and line_status bit 1 (overrun) is set. A rd_status pulse clears bit 1.
- R10: irq equals irq_en AND line_status bit 0, so a read of the byte removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word length code, 0..3 = 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| irq_en | input | 1 | Data-ready interrupt enable |
| rd_data | input | 1 | Read strobe for the held byte |
| rd_status | input | 1 | Read strobe for line status, clears overrun |
| rx_byte | output | 8 | Held character, right-justified |
| line_status | output | 5 | {break, framing, parity, overrun, ready} |
| irq | output | 1 | Receive-data-ready interrupt |

## Verification
The hardest situation to reach is the recovery after a break. The line has to stay low through a whole frame, and then stay low long enough that a receiver arming on level instead of on a high-to-low edge would start a false character. The stimulus holds the line low for more than thirty bit periods and reads the break character in the middle of that time. It then checks that nothing new appears before the line rises, and that a normal character is received once the line has gone high. False starts are produced by low pulses shorter than half a bit, so the line is already high again when the start bit is checked at its centre.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rx_tags_t;

    localparam int TAG_W = 3;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_in,
    output logic rx_level,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[STAGES-2:0], rx_in};
        if (tick) begin
            s_d.last = s_q.sh[STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sh   <= '1;
            s_q.last <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_level = s_q.sh[STAGES-1];
    assign fall     = tick & s_q.last & ~rx_level;

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_level,
    input  logic              fall,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] char_out,
    output rx_tags_t          tags_out
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BCW   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BCW-1:0]    bits;
        logic [DATA_W-1:0] shreg;
        logic              par;
        logic              ones;
        logic              pe_acc;
        logic              done;
        logic [DATA_W-1:0] chr;
        rx_tags_t          tags;
    } fr_t;

    fr_t f_d, f_q;
    logic [BCW-1:0] nbits;
    logic           mid;

    assign nbits = BCW'(DATA_W - 3) + BCW'(wlen);
    assign mid   = tick && (f_q.cnt == FULL_M1);

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (fall) begin
                    f_d.st  = ST_START;
                    f_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (f_q.cnt == HALF_M1) begin
                        f_d.cnt = '0;
                        if (rx_level) begin
                            f_d.st = ST_IDLE;
                        end else begin
                            f_d.st     = ST_DATA;
                            f_d.bits   = '0;
                            f_d.shreg  = '0;
                            f_d.par    = 1'b0;
                            f_d.ones   = 1'b0;
                            f_d.pe_acc = 1'b0;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (mid) begin
                    f_d.cnt   = '0;
                    f_d.shreg = {rx_level, f_q.shreg[DATA_W-1:1]};
                    f_d.par   = f_q.par ^ rx_level;
                    f_d.ones  = f_q.ones | rx_level;
                    f_d.bits  = f_q.bits + 1'b1;
                    if (f_q.bits == nbits - 1'b1) begin
                        f_d.st = par_en ? ST_PAR : ST_STOP;
                    end
                end else if (tick) begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (mid) begin
                    f_d.cnt    = '0;
                    f_d.ones   = f_q.ones | rx_level;
                    f_d.pe_acc = par_odd ? ~(f_q.par ^ rx_level) : (f_q.par ^ rx_level);
                    f_d.st     = ST_STOP;
                end else if (tick) begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (mid) begin
                    f_d.cnt      = '0;
                    f_d.done     = 1'b1;
                    f_d.chr      = f_q.shreg >> (DATA_W - int'(nbits));
                    f_d.tags.fe  = ~rx_level;
                    f_d.tags.brk = ~(f_q.ones | rx_level);
                    f_d.tags.pe  = par_en & f_q.pe_acc;
                    f_d.st       = ST_IDLE;
                end else if (tick) begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign done     = f_q.done;
    assign char_out = f_q.chr;
    assign tags_out = f_q.tags;

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick)); // R2
    AST_BREAK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tags_out.brk) |-> (tags_out.fe && char_out == '0)); // R6
    AST_START_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_START && $past(f_q.st == ST_IDLE)) |-> $past(fall)); // R2
    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_START && tick && f_q.cnt == HALF_M1 && rx_level) |=> (f_q.st == ST_IDLE)); // R2

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] char_in,
    input  rx_tags_t          tags_in,
    input  logic              rd_data,
    input  logic              rd_status,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic [4:0]        line_status,
    output logic              irq
);
    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] data;
        rx_tags_t          tags;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (rd_data) begin
            h_d.full = 1'b0;
            h_d.tags = '0;
        end
        if (rd_status) begin
            h_d.ovr = 1'b0;
        end
        if (done) begin
            h_d.data = char_in;
            h_d.tags = tags_in;
            h_d.full = 1'b1;
            if (h_q.full && !rd_data) begin
                h_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign rx_byte     = h_q.data;
    assign line_status = {h_q.tags.brk, h_q.tags.fe, h_q.tags.pe, h_q.ovr, h_q.full};
    assign irq         = irq_en & h_q.full;

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> (line_status[0] == 1'b0 && line_status[4:2] == 3'b000)); // R8
    AST_EMPTY_NO_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_status[0] |-> (line_status[4:2] == 3'b000)); // R7
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && line_status[0] && !rd_data) |=> line_status[1]); // R9
    AST_IRQ_DROPS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !irq); // R10

endmodule

// File: rtl/uart_tagged_rx.sv
module uart_tagged_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_line,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              irq_en,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_byte,
    output logic [4:0]        line_status,
    output logic              irq
);
    logic              rx_level;
    logic              fall;
    logic              done;
    logic [DATA_W-1:0] chr;
    rx_tags_t          tags;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx_in    (rx_line),
        .rx_level (rx_level),
        .fall     (fall)
    );

    uart_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) framer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx_level (rx_level),
        .fall     (fall),
        .wlen     (cfg_wlen),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .done     (done),
        .char_out (chr),
        .tags_out (tags)
    );

    uart_rx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .char_in     (chr),
        .tags_in     (tags),
        .rd_data     (rd_data),
        .rd_status   (rd_status),
        .irq_en      (irq_en),
        .rx_byte     (rx_byte),
        .line_status (line_status),
        .irq         (irq)
    );

endmodule

// File: tb/uart_tagged_rx_tb_top.sv
module uart_tagged_rx_tb_top;
    localparam int BITCLK = 64;

    typedef struct packed {
        logic [1:0] wlen;
        logic       pen;
        logic       podd;
        logic [7:0] data;
        logic       flip;
        logic       stop;
        logic [7:0] exp_byte;
        logic [4:0] exp_ls;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 5'h01},
        '{2'd0, 1'b0, 1'b0, 8'h37, 1'b0, 1'b1, 8'h17, 5'h01},
        '{2'd3, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 5'h01},
        '{2'd3, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, 8'h3C, 5'h01},
        '{2'd3, 1'b1, 1'b0, 8'h01, 1'b1, 1'b1, 8'h01, 5'h05},
        '{2'd2, 1'b1, 1'b1, 8'h55, 1'b1, 1'b1, 8'h55, 5'h05},
        '{2'd3, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 8'h81, 5'h09},
        '{2'd1, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b1, 8'h2A, 5'h01}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       tick16;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_byte;
    logic [4:0] line_status;
    logic       irq;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd3);

    uart_tagged_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .irq_en(irq_en), .rd_data(rd_data), .rd_status(rd_status),
        .rx_byte(rx_byte), .line_status(line_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                             input logic podd, input logic flip, input logic stop);
        int         nb;
        logic [7:0] m;
        logic       pb;
        nb = 5 + int'(wl);
        m  = 8'hFF >> (8 - nb);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = podd;
        @(negedge clk);
        rx_line = 1'b0;
        wait_clk(BITCLK);
        for (int i = 0; i < nb; i++) begin
            rx_line = d[i];
            wait_clk(BITCLK);
        end
        if (pen) begin
            pb = podd ? ~^(d & m) : ^(d & m);
            rx_line = pb ^ flip;
            wait_clk(BITCLK);
        end
        rx_line = stop;
        wait_clk(BITCLK);
        rx_line = 1'b1;
        wait_clk(BITCLK);
    endtask

    task automatic pulse_rd_data();
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
        wait_clk(1);
    endtask

    task automatic pulse_rd_status();
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        wait_clk(5);
        chk("R1 line_status after reset", 32'(line_status), 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        wait_clk(BITCLK);
        chk("R1 line_status idle", 32'(line_status), 32'h0);

        // R3 R4 R5 R7 R8 table walk
        for (int v = 0; v < NV; v++) begin
            send_char(VECS[v].data, VECS[v].wlen, VECS[v].pen, VECS[v].podd,
                      VECS[v].flip, VECS[v].stop);
            chk($sformatf("R3 vector %0d byte", v), 32'(rx_byte), 32'(VECS[v].exp_byte));
            chk($sformatf("R4/R5 vector %0d status", v), 32'(line_status), 32'(VECS[v].exp_ls));
            pulse_rd_data();
            chk($sformatf("R8 vector %0d status after read", v), 32'(line_status), 32'h0);
        end

        // R2 false start: low for 4 ticks only
        @(negedge clk); rx_line = 1'b0;
        wait_clk(16);
        rx_line = 1'b1;
        wait_clk(12 * BITCLK);
        chk("R2 false start gives no char", 32'(line_status[0]), 32'h0);
        send_char(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R2 char after false start", 32'(rx_byte), 32'hC3);
        pulse_rd_data();

        // R6 break then hold low
        cfg_wlen = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        @(negedge clk); rx_line = 1'b0;
        wait_clk(12 * BITCLK);
        chk("R6 break status", 32'(line_status), 32'h19);
        chk("R6 break byte", 32'(rx_byte), 32'h0);
        pulse_rd_data();
        wait_clk(20 * BITCLK);
        chk("R6 no start while line stays low", 32'(line_status[0]), 32'h0);
        rx_line = 1'b1;
        wait_clk(BITCLK);
        send_char(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 char after break recovery", 32'(rx_byte), 32'h5A);
        chk("R6 status after break recovery", 32'(line_status), 32'h01);
        pulse_rd_data();

        // R9 overrun
        send_char(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        send_char(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 overrun byte replaced", 32'(rx_byte), 32'h22);
        chk("R9 overrun status with new tags", 32'(line_status), 32'h0B);
        pulse_rd_status();
        chk("R9 status read clears overrun", 32'(line_status), 32'h09);
        pulse_rd_data();
        chk("R9 empty after reads", 32'(line_status), 32'h0);

        // R10 interrupt
        irq_en = 1'b1;
        send_char(8'h7E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 irq with data and enable", 32'(irq), 32'h1);
        irq_en = 1'b0;
        wait_clk(1);
        chk("R10 irq masked", 32'(irq), 32'h0);
        irq_en = 1'b1;
        wait_clk(1);
        pulse_rd_data();
        chk("R10 irq cleared by read", 32'(irq), 32'h0);
        chk("R7 ready clear after read", 32'(line_status[0]), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule